// File: doc/BRIEF.md
# DS3 FEBE and AIC overhead monitor

This block sits behind a DS3 receive framer that has already found M-frame alignment. It follows the serial bit stream through the frame using a start-of-frame strobe and a bit-valid qualifier. From the overhead positions it picks out the application identification channel (AIC) bit and the three far-end block error (FEBE) bits.

The FEBE code of every frame is compared against the all-ones pattern, which means "no error". Each other code adds one to a saturating event counter. The host reads the counter as two byte registers. A status register shows the latest AIC value and FEBE code. A latched interrupt bit is set when AIC changes between frames, and reading the interrupt register clears it.

The frame geometry is set by parameters. The defaults are 7 subframes of 8 blocks, and each block is one overhead bit followed by 84 payload bits.

Top module: `ds3_oh_monitor`

## Requirements
- R1: After reset, every readable register returns 8'h00.
- R2: Frame positions are counted from the bit that carries `frame_start`. AIC is the overhead bit of block 2 (0-based) in subframe 0. The FEBE code is made from the overhead bits of blocks 2, 4 and 6 in subframe 3, with the first of them as the MSB. No payload bit or other overhead bit affects any register, and cycles with `bit_valid` low are skipped.
- R3: Address 8'h11 reads {4'b0, latest AIC, latest 3-bit FEBE code}.
- R4: A FEBE code of 3'b111 leaves the event counter unchanged.
- R5: Any other FEBE code adds exactly one to the event counter for that frame.
- R6: The event counter (CNT_W bits, up to 16) stops at its all-ones value.
- R7: Address 8'h59 returns the counter's low byte and latches the high byte in the same read. Address 8'h58 returns that latched high byte.
- R8: When a frame's AIC differs from the previous frame's AIC, bit 2 of address 8'h13 is set and stays set.
- R9: A read of 8'h13 returns the current value and then clears it. A change that is detected in the same cycle as the read wins, and the bit stays set.
- R10: The first frame after reset only loads the AIC reference and never sets the interrupt.
- R11: Unmapped addresses read 8'h00 and have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Received DS3 data bit |
| bit_valid | input | 1 | Qualifies `ser_bit` in this cycle |
| frame_start | input | 1 | Marks the first bit of an M-frame (used with `bit_valid`) |
| rd_en | input | 1 | Host read strobe, side effects on the clock edge |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |

## Verification
The assertions assume that the upstream framer raises `frame_start` only together with `bit_valid` and exactly once per frame length. They also assume that the host reads the low counter byte before the high byte. The stimulus builds each frame bit by bit from the parameterised geometry. It fills every non-monitored position with random data and inserts idle cycles in some frames. Counter reads always go through 8'h59 first, so the latched high byte is always the one the assertions and checks expect.

// File: rtl/ds3_oh_monitor.sv
module ds3_oh_monitor #(
  parameter int PAYLOAD_BITS = 84,
  parameter int BLOCKS       = 8,
  parameter int SUBFRAMES    = 7,
  parameter int CNT_W        = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_bit,
  input  logic       bit_valid,
  input  logic       frame_start,
  input  logic       rd_en,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam int PW = $clog2(PAYLOAD_BITS + 1);
  localparam int BW = $clog2(BLOCKS);
  localparam int SW = $clog2(SUBFRAMES);
  localparam logic [7:0] A_STAT = 8'h11, A_IRQ = 8'h13, A_HI = 8'h58, A_LO = 8'h59;

  logic [PW-1:0] pay_q, pay_c;
  logic [BW-1:0] blk_q, blk_c;
  logic [SW-1:0] sub_q, sub_c;
  logic [1:0] febe_sh;
  logic [2:0] febe_q;
  logic aic_q, have_ref, aic_irq;
  logic [CNT_W-1:0] cnt;
  logic [15:0] cnt16;
  logic [7:0] hi_hold;

  assign pay_c = frame_start ? '0 : pay_q;
  assign blk_c = frame_start ? '0 : blk_q;
  assign sub_c = frame_start ? '0 : sub_q;

  wire oh_bit    = bit_valid && pay_c == '0;
  wire aic_hit   = oh_bit && sub_c == SW'(0) && blk_c == BW'(2);
  wire febe_sub  = oh_bit && sub_c == SW'(3);
  wire febe_take = febe_sub && (blk_c == BW'(2) || blk_c == BW'(4));
  wire febe_last = febe_sub && blk_c == BW'(6);
  wire [2:0] new_code = {febe_sh, ser_bit};
  wire cnt_max = &cnt;
  wire aic_chg = aic_hit && have_ref && ser_bit != aic_q;
  wire irq_rd  = rd_en && rd_addr == A_IRQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pay_q <= '0; blk_q <= '0; sub_q <= '0;
    end else if (bit_valid) begin
      if (pay_c == PW'(PAYLOAD_BITS)) begin
        pay_q <= '0;
        if (blk_c == BW'(BLOCKS - 1)) begin
          blk_q <= '0;
          sub_q <= (sub_c == SW'(SUBFRAMES - 1)) ? '0 : sub_c + 1'b1;
        end else begin
          blk_q <= blk_c + 1'b1;
          sub_q <= sub_c;
        end
      end else begin
        pay_q <= pay_c + 1'b1;
        blk_q <= blk_c;
        sub_q <= sub_c;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      febe_sh <= '0; febe_q <= '0; cnt <= '0;
    end else begin
      if (febe_take) febe_sh <= {febe_sh[0], ser_bit};
      if (febe_last) begin
        febe_q <= new_code;
        if (new_code != 3'b111 && !cnt_max) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aic_q <= 1'b0; have_ref <= 1'b0; aic_irq <= 1'b0;
    end else begin
      if (aic_hit) begin
        aic_q    <= ser_bit;
        have_ref <= 1'b1;
      end
      if (aic_chg) aic_irq <= 1'b1;
      else if (irq_rd) aic_irq <= 1'b0;
    end
  end

  always_comb begin
    cnt16 = '0;
    cnt16[CNT_W-1:0] = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hi_hold <= '0;
    else if (rd_en && rd_addr == A_LO) hi_hold <= cnt16[15:8];
  end

  always_comb begin
    case (rd_addr)
      A_STAT:  rd_data = {4'b0, aic_q, febe_q};
      A_IRQ:   rd_data = {5'b0, aic_irq, 2'b0};
      A_HI:    rd_data = hi_hold;
      A_LO:    rd_data = cnt16[7:0];
      default: rd_data = 8'h00;
    endcase
  end

  assert_no_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (febe_last && new_code == 3'b111) |=> $stable(cnt));
  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1 && $past(febe_last)));
  assert_cnt_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_max |=> cnt_max);
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aic_irq) |-> aic_q != $past(aic_q));
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rd && !aic_hit) |=> !aic_irq);
  assert_first_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (aic_hit && !have_ref) |=> !aic_irq);
endmodule

// File: tb/tb_ds3_oh_monitor.sv
module tb_ds3_oh_monitor;
  localparam int PERIOD = 10;
  localparam int PAY = 1, BLK = 8, SUB = 7, CW = 9;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, ser_bit = 0, bit_valid = 0, frame_start = 0, rd_en = 0;
  logic [7:0] rd_addr = 0, rd_data, snoop;
  int n_chk = 0, n_fail = 0;
  int exp_cnt = 0;
  logic exp_aic = 0, exp_irq = 0, have_ref = 0;
  logic [2:0] exp_code = 0;
  logic [7:0] d, lo, hi;
  logic done = 0;

  ds3_oh_monitor #(.PAYLOAD_BITS(PAY), .BLOCKS(BLK), .SUBFRAMES(SUB), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .bit_valid(bit_valid),
    .frame_start(frame_start), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; rd_addr = a; #1 v = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic send_frame(input logic aic, input logic [2:0] code, input bit gap, input bit rd_at_aic);
    for (int s = 0; s < SUB; s++)
      for (int b = 0; b < BLK; b++)
        for (int p = 0; p <= PAY; p++) begin
          @(negedge clk);
          rd_en = 0;
          if (gap && p == 1) begin
            bit_valid = 0; frame_start = 0; ser_bit = $urandom;
            @(negedge clk);
          end
          bit_valid = 1;
          frame_start = (s == 0 && b == 0 && p == 0);
          ser_bit = $urandom;
          if (p == 0 && s == 0 && b == 2) begin
            ser_bit = aic;
            if (rd_at_aic) begin rd_en = 1; rd_addr = 8'h13; #1 snoop = rd_data; end
          end
          if (p == 0 && s == 3 && b == 2) ser_bit = code[2];
          if (p == 0 && s == 3 && b == 4) ser_bit = code[1];
          if (p == 0 && s == 3 && b == 6) ser_bit = code[0];
        end
    @(negedge clk); bit_valid = 0; frame_start = 0; rd_en = 0;
    if (code != 3'b111 && exp_cnt < CMAX) exp_cnt++;
    if (have_ref && aic != exp_aic) exp_irq = 1;
    have_ref = 1; exp_aic = aic; exp_code = code;
  endtask

  task automatic chk_cnt(input string req);
    rd(8'h59, lo); rd(8'h58, hi);
    chk(req, {hi, lo}, exp_cnt);
  endtask

  task automatic chk_all(input string tag);
    rd(8'h11, d); chk({"R3 R2 status ", tag}, d, {4'b0, exp_aic, exp_code});
    chk_cnt({"R4 R5 count ", tag});
    rd(8'h13, d); chk({"R8 irq ", tag}, d, {5'b0, exp_irq, 2'b0});
    exp_irq = 0;
    rd(8'h13, d); chk({"R9 cleared ", tag}, d, 0);
  endtask

  initial begin
    #(PERIOD * 190000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h11, d); chk("R1 status", d, 0);
    rd(8'h13, d); chk("R1 irq", d, 0);
    rd(8'h59, d); chk("R1 cnt lo", d, 0);
    rd(8'h58, d); chk("R1 cnt hi", d, 0);
    for (int a = 0; a < 256; a += 17) begin
      if (a == 8'h11 || a == 8'h13 || a == 8'h58 || a == 8'h59) continue;
      rd(8'(a), d); chk("R11 unmapped", d, 0);
    end

    send_frame(1, 3'b111, 0, 0);
    chk_all("first frame R10");

    for (int pass = 0; pass < 2; pass++)
      for (int c = 0; c < 8; c++) begin
        send_frame(logic'((c + pass) % 3 == 0), 3'(c), bit'(c & 1), 0);
        chk_all($sformatf("sweep p%0d c%0d", pass, c));
      end

    send_frame(~exp_aic, 3'b111, 0, 0);
    send_frame(~exp_aic, 3'b111, 1, 1);
    chk("R9 read during set", snoop, 8'h04);
    rd(8'h13, d); chk("R9 set wins over clear", d, 8'h04);
    exp_irq = 0;

    while (exp_cnt < 255) send_frame(exp_aic, 3'b010, 0, 0);
    rd(8'h59, lo); chk("R7 low at 255", lo, 8'hFF);
    send_frame(exp_aic, 3'b000, 0, 0);
    rd(8'h58, hi); chk("R7 high latched", hi, 0);
    chk_cnt("R7 after reread");

    while (exp_cnt < CMAX) send_frame(exp_aic, 3'b101, 0, 0);
    for (int k = 0; k < 3; k++) send_frame(exp_aic, 3'b001, 0, 0);
    chk_cnt("R6 saturated");
    chk("R6 model", exp_cnt, CMAX);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule